// File: doc/BRIEF.md
# Addressing Mode and Result Destination Decoder

This combinational block sits in the decode stage of an 8-bit accumulator machine. It takes the instruction's class and its 3-bit mode field, and turns them into two results. The first is the RAM address, built from the immediate byte and the current X and Y registers. The second is the load enable of the single result register that takes the ALU result bus. It also raises the RAM write strobe for stores and asks the X register to step forward in the post-increment form.

The load, ALU and store classes share one mode decoder. A store adds no addressing logic of its own. It only masks the accumulator and output-port enables, so it can use every addressing form. The X and Y enables stay open during a store. A store in a mode whose destination is X or Y therefore writes AC to memory and copies AC into that register in the same cycle.

Top module: `mode_dest_decoder`

## Requirements
- R1: The class input `op_class` uses these codes: 0 = load, 1 = ALU, 2 = store, 3 = idle. The mode input `mode` uses these codes: 0 = [D]→AC, 1 = [X]→AC, 2 = [Y,D]→AC, 3 = [Y,X]→AC, 4 = [D]→X, 5 = [D]→Y, 6 = [D]→OUT, 7 = [Y,X++]→OUT.
- R2: The address is {high, low}, as follows:
  - Modes 0, 4, 5 and 6 give {0, D}.
  - Mode 1 gives {0, X}.
  - Mode 2 gives {Y, D}.
  - Modes 3 and 7 give {Y, X}.
- R3: For the load and ALU classes, exactly one of `ld_ac`, `ld_x`, `ld_y`, `ld_out` is high. It is the one that the mode names.
- R4: For the store class, `ld_ac` and `ld_out` are low in every mode.
- R5: For the store class, mode 4 raises `ld_x` and mode 5 raises `ld_y`. These are the same enables that a load in those modes raises.
- R6: `ram_we` is high exactly when the class is store.
- R7: `x_inc` is high exactly in mode 7 for the load, ALU and store classes. `x_inc_val` always equals X+1 modulo 256, so 255 wraps to 0.
- R8: In the idle class, all of the following are low: every load enable, `ram_we` and `x_inc`.
- R9: The address outputs depend only on the mode, D, X and Y. They are the same for every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Instruction class code |
| mode | input | 3 | Addressing/destination mode field |
| imm_d | input | 8 | Immediate byte D |
| reg_x | input | 8 | Current X register value |
| reg_y | input | 8 | Current Y register value |
| ram_addr_hi | output | 8 | RAM address high byte |
| ram_addr_lo | output | 8 | RAM address low byte |
| ram_we | output | 1 | RAM write enable |
| ld_ac | output | 1 | Accumulator load enable |
| ld_x | output | 1 | X load enable |
| ld_y | output | 1 | Y load enable |
| ld_out | output | 1 | Output port load enable |
| x_inc | output | 1 | Request to replace X by its incremented value |
| x_inc_val | output | 8 | X plus one, modulo 256 |

## Verification
Every pair of class and mode is tried many times with random D, X and Y. Random operands separate the D, X and Y address sources, where a fixed operand could hide a swapped or stuck byte. Repeating each mode under all four classes tells store masking apart from load decoding, and shows that the address does not follow the class. Directed vectors set X to 255 and to 0 to expose the increment wrap. They also set D, X and Y to all-ones and to distinct values, so that a page-zero form leaking Y onto the high byte is seen.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int MODE_W = 3;
  localparam int CLS_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_LOAD  = 2'd0,
    CLS_ALU   = 2'd1,
    CLS_STORE = 2'd2,
    CLS_IDLE  = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    ASRC_D     = 3'd0,
    ASRC_X     = 3'd1,
    ASRC_YD    = 3'd2,
    ASRC_YX    = 3'd3,
    ASRC_YXINC = 3'd4
  } addr_src_e;

  typedef enum logic [1:0] {
    DST_AC  = 2'd0,
    DST_X   = 2'd1,
    DST_Y   = 2'd2,
    DST_OUT = 2'd3
  } dest_e;
endpackage

// File: rtl/mode_field_decode.sv
module mode_field_decode
  import addr_dec_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output addr_src_e         addr_src,
  output dest_e             dest
);
  // R1: mode table, shared by every class
  always_comb begin
    addr_src = ASRC_D;
    dest     = DST_AC;
    case (mode)
      3'd0: begin addr_src = ASRC_D;     dest = DST_AC;  end
      3'd1: begin addr_src = ASRC_X;     dest = DST_AC;  end
      3'd2: begin addr_src = ASRC_YD;    dest = DST_AC;  end
      3'd3: begin addr_src = ASRC_YX;    dest = DST_AC;  end
      3'd4: begin addr_src = ASRC_D;     dest = DST_X;   end
      3'd5: begin addr_src = ASRC_D;     dest = DST_Y;   end
      3'd6: begin addr_src = ASRC_D;     dest = DST_OUT; end
      default: begin addr_src = ASRC_YXINC; dest = DST_OUT; end
    endcase
  end
endmodule

// File: rtl/ram_addr_mux.sv
module ram_addr_mux
  import addr_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  addr_src_e         addr_src,
  input  logic              active,
  input  logic [DATA_W-1:0] imm_d,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  output logic [DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] addr_lo,
  output logic              x_inc,
  output logic [DATA_W-1:0] x_inc_val
);
  localparam logic [DATA_W-1:0] PAGE_ZERO = '0;
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);

  logic y_page;
  logic lo_from_x;

  always_comb begin
    y_page    = (addr_src == ASRC_YD) || (addr_src == ASRC_YX) ||
                (addr_src == ASRC_YXINC);
    lo_from_x = (addr_src == ASRC_X) || (addr_src == ASRC_YX) ||
                (addr_src == ASRC_YXINC);
    addr_hi   = y_page ? reg_y : PAGE_ZERO;
    addr_lo   = lo_from_x ? reg_x : imm_d;
    x_inc     = active && (addr_src == ASRC_YXINC);
    x_inc_val = reg_x + ONE;
  end

  always_comb begin
    // R2
    zero_page_chk: assert (y_page || addr_hi == PAGE_ZERO)
      else $error("page-zero form drove a nonzero high byte");
    // R7
    inc_uses_x_chk: assert (!x_inc || (addr_lo == reg_x && addr_hi == reg_y))
      else $error("post-increment access not at {Y,X}");
  end
endmodule

// File: rtl/dest_enable.sv
module dest_enable
  import addr_dec_pkg::*;
(
  input  op_class_e cls,
  input  dest_e     dest,
  output logic      active,
  output logic      ld_ac,
  output logic      ld_x,
  output logic      ld_y,
  output logic      ld_out,
  output logic      ram_we
);
  logic is_store;

  always_comb begin
    active   = (cls != CLS_IDLE);
    is_store = (cls == CLS_STORE);
    ram_we   = is_store;
    // store gates only AC and OUT; X and Y stay open
    ld_ac    = active && !is_store && (dest == DST_AC);
    ld_out   = active && !is_store && (dest == DST_OUT);
    ld_x     = active && (dest == DST_X);
    ld_y     = active && (dest == DST_Y);
  end

  always_comb begin
    // R3
    one_dest_chk: assert ($onehot0({ld_ac, ld_x, ld_y, ld_out}))
      else $error("more than one result register enabled");
    // R4
    store_mask_chk: assert (!ram_we || (!ld_ac && !ld_out))
      else $error("store loaded AC or OUT");
  end
endmodule

// File: rtl/mode_dest_decoder.sv
module mode_dest_decoder
  import addr_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [CLS_W-1:0]  op_class,
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] imm_d,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  output logic [DATA_W-1:0] ram_addr_hi,
  output logic [DATA_W-1:0] ram_addr_lo,
  output logic              ram_we,
  output logic              ld_ac,
  output logic              ld_x,
  output logic              ld_y,
  output logic              ld_out,
  output logic              x_inc,
  output logic [DATA_W-1:0] x_inc_val
);
  addr_src_e addr_src;
  dest_e     dest;
  logic      active;

  mode_field_decode u_mode (
    .mode     (mode),
    .addr_src (addr_src),
    .dest     (dest)
  );

  dest_enable u_dest (
    .cls    (op_class_e'(op_class)),
    .dest   (dest),
    .active (active),
    .ld_ac  (ld_ac),
    .ld_x   (ld_x),
    .ld_y   (ld_y),
    .ld_out (ld_out),
    .ram_we (ram_we)
  );

  ram_addr_mux #(.DATA_W(DATA_W)) u_addr (
    .addr_src  (addr_src),
    .active    (active),
    .imm_d     (imm_d),
    .reg_x     (reg_x),
    .reg_y     (reg_y),
    .addr_hi   (ram_addr_hi),
    .addr_lo   (ram_addr_lo),
    .x_inc     (x_inc),
    .x_inc_val (x_inc_val)
  );

  always_comb begin
    // R8
    idle_quiet_chk: assert (op_class != CLS_IDLE ||
                            !(ld_ac || ld_x || ld_y || ld_out || ram_we || x_inc))
      else $error("idle class produced an enable");
    // R5
    store_copy_chk: assert (!(ram_we && (mode == 3'd4 || mode == 3'd5)) ||
                            (ld_x ^ ld_y))
      else $error("store to X/Y mode lost its register copy");
  end
endmodule

// File: tb/mode_dest_decoder_tb.sv
module mode_dest_decoder_tb;
  logic clk;
  logic [1:0] op_class;
  logic [2:0] mode;
  logic [7:0] imm_d, reg_x, reg_y;
  logic [7:0] ram_addr_hi, ram_addr_lo, x_inc_val;
  logic ram_we, ld_ac, ld_x, ld_y, ld_out, x_inc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 0;
  always #4 clk = ~clk;

  mode_dest_decoder u_dut (
    .op_class(op_class), .mode(mode), .imm_d(imm_d), .reg_x(reg_x), .reg_y(reg_y),
    .ram_addr_hi(ram_addr_hi), .ram_addr_lo(ram_addr_lo), .ram_we(ram_we),
    .ld_ac(ld_ac), .ld_x(ld_x), .ld_y(ld_y), .ld_out(ld_out),
    .x_inc(x_inc), .x_inc_val(x_inc_val)
  );

  function automatic logic [15:0] exp_addr(logic [2:0] m, logic [7:0] d, logic [7:0] x, logic [7:0] y);
    case (m)
      3'd1:       return {8'h00, x};
      3'd2:       return {y, d};
      3'd3, 3'd7: return {y, x};
      default:    return {8'h00, d};
    endcase
  endfunction

  // {ac, x, y, out}
  function automatic logic [3:0] exp_loads(logic [1:0] c, logic [2:0] m);
    logic [3:0] v;
    if (c == 2'd3) return 4'b0000;
    case (m)
      3'd4:       v = 4'b0100;
      3'd5:       v = 4'b0010;
      3'd6, 3'd7: v = 4'b0001;
      default:    v = 4'b1000;
    endcase
    if (c == 2'd2) v = v & 4'b0110;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cls=%0d mode=%0d d=%h x=%h y=%h actual=%h expected=%h",
               req, op_class, mode, imm_d, reg_x, reg_y, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] c, logic [2:0] m, logic [7:0] d, logic [7:0] x, logic [7:0] y);
    string lreq;
    @(posedge clk);
    op_class = c; mode = m; imm_d = d; reg_x = x; reg_y = y;
    @(negedge clk);
    chk((c == 2'd3) ? "R8" : "R2", {16'h0, ram_addr_hi, ram_addr_lo}, {16'h0, exp_addr(m, d, x, y)});
    lreq = (c == 2'd3) ? "R8" : (c == 2'd2) ? ((m == 3'd4 || m == 3'd5) ? "R5" : "R4") : "R3";
    chk(lreq, {28'h0, ld_ac, ld_x, ld_y, ld_out}, {28'h0, exp_loads(c, m)});
    chk((c == 2'd3) ? "R8" : "R6", {31'h0, ram_we}, {31'h0, c == 2'd2});
    chk((c == 2'd3) ? "R8" : "R7", {23'h0, x_inc, x_inc_val},
        {23'h0, (c != 2'd3) && (m == 3'd7), x + 8'd1});
  endtask

  initial begin
    void'($urandom(32'd7321));
    op_class = 2'd3; mode = 3'd0; imm_d = 8'h00; reg_x = 8'h00; reg_y = 8'h00;
    // R8: quiet state with idle class
    @(negedge clk);
    chk("R8", {26'h0, ld_ac, ld_x, ld_y, ld_out, ram_we, x_inc}, 32'h0);
    // directed corners: wrap (R7), distinct bytes and all-ones (R2, R9)
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 8; m++) begin
        apply(2'(c), 3'(m), 8'hA5, 8'hFF, 8'h3C);
        apply(2'(c), 3'(m), 8'hFF, 8'h00, 8'hFF);
        apply(2'(c), 3'(m), 8'h12, 8'h34, 8'h56);
      end
    end
    // R1, R9: every class/mode pair under random operands
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < 4; c++) begin
        for (int m = 0; m < 8; m++) begin
          apply(2'(c), 3'(m), 8'($urandom), 8'($urandom), 8'($urandom));
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule